// File: doc/BRIEF.md
# Sixteen-Bit Timer with Three Compare Channels

This block is a 16-bit up-counter that advances on a prescaled clock enable taken from the system clock. Software picks a division ratio through a 3-bit clock selection, and a 4-bit counting mode split across two control fields. The counter can count freely and wrap, or it can clear itself on a match against compare channel A or against a separate top/capture register.

Three compare channels (A, B, C) each set a flag when the counter matches them. The block also keeps an overflow flag and a capture-match flag. Flags are sticky until software clears them with a write-one strobe. Each flag drives its own interrupt line through a mask bit. Software may load the counter directly. The tick that follows such a load produces no match events, so loading a compare value or the top value skips that event.

Top module: `timer16_cmp`

## Requirements
- R1: Clock selection 0 holds the counter. Selections 1, 2, 3, 4 and 5 advance it by one every 1, 8, 64, 256 and 1024 system clocks respectively.
- R2: Selections 6 and 7 hold the counter exactly as selection 0 does.
- R3: The mode code is {modeHi, modeLo}. Code 4 clears the counter on a compare-A match. Code 12 clears it on a top/capture match. Every other code counts freely, like code 0.
- R4: In free counting, an advance from 0xFFFF gives 0 and sets flag bit 0 (overflow).
- R5: In mode 4, an advance taken while the counter equals cmpA loads 0 instead of incrementing. The counter therefore cycles with period cmpA+1.
- R6: In mode 12, an advance taken while the counter equals topCap loads 0 and sets flag bit 5 (capture match).
- R7: An advance taken while the counter equals cmpA, cmpB or cmpC sets flag bit 1, 2 or 3 respectively, in every mode.
- R8: A pulse on cntWrEn loads cntWrData at the next clock edge and takes priority over an advance at that edge. The first advance after the load sets no compare or capture flag and does no clear-on-match.
- R9: When counting starts from a stopped selection, the prescaler starts from zero, so the first advance comes exactly one full division period after the start.
- R10: A 1 in flagClr clears the matching flag bit and a 0 leaves it unchanged. A flag set in the same cycle as its clear stays set. Bits 4, 6 and 7 always read 0.
- R11: Each interrupt line is high exactly when its flag bit and its mask bit are both 1. The bit layout is 0 overflow, 1 A, 2 B, 3 C, 5 capture.
- R12: Synchronous reset clears the counter, the prescaler and every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clkSel | input | 3 | Clock selection |
| modeLo | input | 2 | Low two bits of the mode code |
| modeHi | input | 2 | High two bits of the mode code |
| cmpA | input | 16 | Compare channel A value |
| cmpB | input | 16 | Compare channel B value |
| cmpC | input | 16 | Compare channel C value |
| topCap | input | 16 | Top/capture value used in mode 12 |
| intMask | input | 8 | Interrupt mask, same layout as the flags |
| cntWrEn | input | 1 | Counter load strobe |
| cntWrData | input | 16 | Counter load value |
| flagClr | input | 8 | Write-one-to-clear flag strobe |
| count | output | 16 | Counter value |
| flags | output | 8 | Flag register |
| irqOvf | output | 1 | Overflow interrupt |
| irqCmpA | output | 1 | Compare A interrupt |
| irqCmpB | output | 1 | Compare B interrupt |
| irqCmpC | output | 1 | Compare C interrupt |
| irqCap | output | 1 | Capture-match interrupt |

## Verification
The assertions assume that cntWrEn and flagClr are pulses of one cycle driven by software. They also assume that clkSel and the mode fields change only between test phases. The counter-hold property assumes that no advance is taken without a tick. The stimulus changes every input half a cycle away from the active edge. It changes clock selection and mode only after the counter has been stopped or reloaded, so each phase starts from a known count and a zero prescaler. Expected counts then follow from plain division and modulo on the number of edges.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int FLAG_W = 8;
  localparam int FB_OVF = 0;
  localparam int FB_CMPA = 1;
  localparam int FB_CMPB = 2;
  localparam int FB_CMPC = 3;
  localparam int FB_CAP = 5;
  localparam logic [FLAG_W-1:0] FLAG_VALID = 8'h2F;

  localparam logic [3:0] MODE_CTC_A = 4'd4;
  localparam logic [3:0] MODE_CTC_TOP = 4'd12;

  typedef struct packed {
    logic              advance;
    logic              clearCnt;
    logic [FLAG_W-1:0] setFlags;
  } tmrStrobes_t;

  // log2 of the division ratio for a running selection
  function automatic logic [3:0] divShift(input logic [2:0] sel);
    case (sel)
      3'd1: divShift = 4'd0;
      3'd2: divShift = 4'd3;
      3'd3: divShift = 4'd6;
      3'd4: divShift = 4'd8;
      3'd5: divShift = 4'd10;
      default: divShift = 4'd0;
    endcase
  endfunction

  function automatic logic selRuns(input logic [2:0] sel);
    selRuns = (sel >= 3'd1) && (sel <= 3'd5);
  endfunction
endpackage

// File: rtl/timer16_presc.sv
module timer16_presc
  import timer16_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clkSel,
  output logic       tick
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] lim;
  logic             running;

  assign running = selRuns(clkSel);
  assign lim     = ~({PSC_W{1'b1}} << divShift(clkSel));
  assign tick    = running && (psc >= lim);

  // Held at zero while stopped, so a start always begins a full period
  always_ff @(posedge clk) begin
    if (rst || !running || tick) psc <= '0;
    else psc <= psc + 1'b1;
  end

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    !running |=> (psc == '0));
endmodule

// File: rtl/timer16_ctrl.sv
module timer16_ctrl
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [2:0]                clkSel,
  input  logic [1:0]                modeLo,
  input  logic [1:0]                modeHi,
  input  logic [NCMP-1:0][CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0]          topCap,
  input  logic [CNT_W-1:0]          count,
  input  logic                      cntWrEn,
  output tmrStrobes_t               strb
);
  logic [3:0]      modeCode;
  logic            ctcA;
  logic            ctcTop;
  logic [NCMP-1:0] cmpHit;
  logic            topHit;
  logic            blockMatch;
  logic            matchOk;

  assign modeCode = {modeHi, modeLo};
  assign ctcA     = (modeCode == MODE_CTC_A);
  assign ctcTop   = (modeCode == MODE_CTC_TOP);
  assign topHit   = (count == topCap);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign cmpHit[i] = (count == cmpVal[i]);
  end

  // One tick of match blanking after a software load
  always_ff @(posedge clk) begin
    if (rst) blockMatch <= 1'b0;
    else if (cntWrEn) blockMatch <= 1'b1;
    else if (tick) blockMatch <= 1'b0;
  end

  assign matchOk = tick && !blockMatch && !cntWrEn;

  always_comb begin
    strb = '0;
    strb.advance  = tick;
    strb.clearCnt = matchOk && ((ctcA && cmpHit[0]) || (ctcTop && topHit));
    strb.setFlags[FB_OVF] = tick && !cntWrEn && (count == {CNT_W{1'b1}});
    for (int i = 0; i < NCMP; i++) strb.setFlags[FB_CMPA+i] = matchOk && cmpHit[i];
    strb.setFlags[FB_CAP] = matchOk && ctcTop && topHit;
  end

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !selRuns(clkSel) |-> !tick);
  p_clear_mode_r3: assert property (@(posedge clk) disable iff (rst)
    strb.clearCnt |-> (ctcA || ctcTop));
endmodule

// File: rtl/timer16_dp.sv
module timer16_dp
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobes_t       strb,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [FLAG_W-1:0] flagClr,
  input  logic [FLAG_W-1:0] intMask,
  output logic [CNT_W-1:0]  count,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] irqVec
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (cntWrEn) count <= cntWrData;
    else if (strb.advance) count <= strb.clearCnt ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else flags <= ((flags & ~flagClr) | strb.setFlags) & FLAG_VALID;
  end

  assign irqVec = flags & intMask;

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    cntWrEn |=> (count == $past(cntWrData)));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!cntWrEn && !strb.advance) |=> $stable(count));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!cntWrEn && strb.advance && (count == {CNT_W{1'b1}})) |=> (count == '0));

  for (genvar b = 0; b < FLAG_W; b++) begin : g_hold
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (flags[b] && !flagClr[b]) |=> flags[b]);
  end
endmodule

// File: rtl/timer16_cmp.sv
module timer16_cmp
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clkSel,
  input  logic [1:0]       modeLo,
  input  logic [1:0]       modeHi,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [CNT_W-1:0] cmpC,
  input  logic [CNT_W-1:0] topCap,
  input  logic [7:0]       intMask,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [7:0]       flagClr,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       flags,
  output logic             irqOvf,
  output logic             irqCmpA,
  output logic             irqCmpB,
  output logic             irqCmpC,
  output logic             irqCap
);
  localparam int NCMP = 3;

  logic                       tick;
  tmrStrobes_t                strb;
  logic [FLAG_W-1:0]          irqVec;
  logic [NCMP-1:0][CNT_W-1:0] cmpVal;

  assign cmpVal = {cmpC, cmpB, cmpA};

  timer16_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .clkSel(clkSel), .tick(tick)
  );

  timer16_ctrl #(.CNT_W(CNT_W), .NCMP(NCMP)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .clkSel(clkSel),
    .modeLo(modeLo), .modeHi(modeHi), .cmpVal(cmpVal), .topCap(topCap),
    .count(count), .cntWrEn(cntWrEn), .strb(strb)
  );

  timer16_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .flagClr(flagClr), .intMask(intMask),
    .count(count), .flags(flags), .irqVec(irqVec)
  );

  assign irqOvf  = irqVec[FB_OVF];
  assign irqCmpA = irqVec[FB_CMPA];
  assign irqCmpB = irqVec[FB_CMPB];
  assign irqCmpC = irqVec[FB_CMPC];
  assign irqCap  = irqVec[FB_CAP];
endmodule

// File: tb/timer16_cmp_test.sv
module timer16_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] clkSel = '0;
  logic [1:0] modeLo = '0, modeHi = '0;
  logic [15:0] cmpA = 16'h8000, cmpB = 16'h8000, cmpC = 16'h8000, topCap = 16'h8000;
  logic [7:0] intMask = '0, flagClr = '0;
  logic cntWrEn = 1'b0;
  logic [15:0] cntWrData = '0;
  logic [15:0] count;
  logic [7:0] flags;
  logic irqOvf, irqCmpA, irqCmpB, irqCmpC, irqCap;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer16_cmp uut (
    .clk(clk), .rst(rst), .clkSel(clkSel), .modeLo(modeLo), .modeHi(modeHi),
    .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC), .topCap(topCap), .intMask(intMask),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .flagClr(flagClr),
    .count(count), .flags(flags), .irqOvf(irqOvf), .irqCmpA(irqCmpA),
    .irqCmpB(irqCmpB), .irqCmpC(irqCmpC), .irqCap(irqCap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic loadCnt(input logic [15:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    step(1);
    cntWrEn = 1'b0;
  endtask

  task automatic clrAll();
    flagClr = 8'hFF;
    step(1);
    flagClr = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3);
    rst = 1'b0;
    // R12: reset state
    check("R12 count", 32'(count), 0);
    check("R12 flags", 32'(flags), 0);
    check("R12 irqs", {irqOvf, irqCmpA, irqCmpB, irqCmpC, irqCap}, 0);

    // R1 / R9: division ratios and restart from stop
    for (int s = 1; s <= 5; s++) begin
      int dv;
      dv = (s == 1) ? 1 : (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      clkSel = 3'd0;
      loadCnt(16'd0);
      step(2);
      clkSel = 3'(s);
      step(3 * dv - 1);
      check("R1 before third advance", 32'(count), 2);
      step(1);
      check("R1 third advance", 32'(count), 3);
      step(dv / 2);
      clkSel = 3'd0;
      step(5);
      check("R1 stopped hold", 32'(count), 3);
      clkSel = 3'(s);
      step(dv - 1);
      check("R9 no early advance", 32'(count), 3);
      step(1);
      check("R9 first advance after restart", 32'(count), 4);
    end

    // R2: external selections hold
    clkSel = 3'd6; step(40);
    check("R2 sel 6 holds", 32'(count), 4);
    clkSel = 3'd7; step(40);
    check("R2 sel 7 holds", 32'(count), 4);

    // R4: wrap and overflow flag
    clkSel = 3'd0; loadCnt(16'hFFFE); clrAll();
    clkSel = 3'd1;
    step(1);
    check("R4 at max", 32'(count), 32'hFFFF);
    check("R4 no flag yet", 32'(flags[0]), 0);
    step(1);
    check("R4 wrap to zero", 32'(count), 0);
    check("R4 overflow flag", 32'(flags[0]), 1);

    // R5: mode 4 clear on compare A
    clkSel = 3'd0; modeHi = 2'b01; modeLo = 2'b00; cmpA = 16'd5;
    loadCnt(16'd0); clrAll();
    clkSel = 3'd1;
    for (int n = 1; n <= 20; n++) begin
      step(1);
      check("R5 count period", 32'(count), 32'(n % 6));
      check("R7 flag A in mode 4", 32'(flags[1]), (n >= 6) ? 1 : 0);
    end

    // R6: mode 12 clear on top/capture
    clkSel = 3'd0; modeHi = 2'b11; modeLo = 2'b00; cmpA = 16'h8000; topCap = 16'd9;
    loadCnt(16'd0); clrAll();
    clkSel = 3'd1;
    for (int n = 1; n <= 25; n++) begin
      step(1);
      check("R6 count period", 32'(count), 32'(n % 10));
      check("R6 capture flag", 32'(flags[5]), (n >= 10) ? 1 : 0);
    end
    check("R6 no compare A flag", 32'(flags[1]), 0);

    // R3: other codes count freely
    for (int m = 0; m < 16; m++) begin
      if (m != 4 && m != 12) begin
        clkSel = 3'd0; {modeHi, modeLo} = 4'(m); cmpA = 16'd5; topCap = 16'd5;
        loadCnt(16'd0);
        clkSel = 3'd1;
        step(12);
        check("R3 free count in other mode", 32'(count), 12);
      end
    end

    // R7: three compare channels in free mode
    clkSel = 3'd0; modeHi = 2'b00; modeLo = 2'b00;
    cmpA = 16'd3; cmpB = 16'd7; cmpC = 16'd11; topCap = 16'h8000;
    loadCnt(16'd0); clrAll();
    clkSel = 3'd1;
    for (int n = 1; n <= 14; n++) begin
      logic [2:0] ex;
      step(1);
      ex = {(n >= 12) ? 1'b1 : 1'b0, (n >= 8) ? 1'b1 : 1'b0, (n >= 4) ? 1'b1 : 1'b0};
      check("R7 compare flags", 32'(flags[3:1]), 32'(ex));
    end

    // R8: load blanks the next match
    clkSel = 3'd0; modeHi = 2'b01; modeLo = 2'b00;
    cmpA = 16'd5; cmpB = 16'd5; cmpC = 16'h8000;
    loadCnt(16'd0); clrAll();
    clkSel = 3'd1;
    step(2);
    loadCnt(16'd5);
    check("R8 loaded value", 32'(count), 5);
    step(1);
    check("R8 skipped clear", 32'(count), 6);
    check("R8 no A/B flags", 32'(flags & 8'h06), 0);
    loadCnt(16'd3);
    step(3);
    check("R8 later clear acts", 32'(count), 0);
    check("R8 later flags set", 32'(flags & 8'h06), 32'h06);

    // R10: write-one-to-clear
    clkSel = 3'd0;
    clrAll();
    check("R10 all cleared", 32'(flags), 0);
    modeHi = 2'b00; cmpA = 16'd7; cmpB = 16'd7; cmpC = 16'd7;
    loadCnt(16'd6);
    clkSel = 3'd1;
    step(2);
    clkSel = 3'd0;
    check("R10 three set", 32'(flags & 8'h0E), 32'h0E);
    flagClr = 8'h00; step(1);
    check("R10 zero leaves flags", 32'(flags & 8'h0E), 32'h0E);
    flagClr = 8'h02; step(1); flagClr = 8'h00;
    check("R10 clear A only", 32'(flags & 8'h0E), 32'h0C);
    flagClr = 8'hD0; step(1); flagClr = 8'h00;
    check("R10 reserved bits zero", 32'(flags & 8'hD0), 0);
    loadCnt(16'd6);
    clkSel = 3'd1;
    step(1);
    flagClr = 8'h02; step(1); flagClr = 8'h00;
    clkSel = 3'd0;
    check("R10 set wins over clear", 32'(flags[1]), 1);

    // R11: mask gating, flags brought to a known set
    cmpA = 16'hFFFF; cmpB = 16'h8000; cmpC = 16'hFFFF;
    modeHi = 2'b11; topCap = 16'hFFFF;
    clrAll();
    loadCnt(16'hFFFE);
    clkSel = 3'd1; step(2); clkSel = 3'd0;
    check("R11 flag setup", 32'(flags), 32'h2B);
    for (int k = 0; k < 64; k++) begin
      logic [7:0] m;
      m = 8'(k);
      intMask = m; step(1);
      check("R11 irq lines", {27'd0, irqCap, irqCmpC, irqCmpB, irqCmpA, irqOvf},
            {27'd0, m[5] & flags[5], m[3] & flags[3], m[2] & flags[2],
             m[1] & flags[1], m[0] & flags[0]});
    end

    // R12: reset mid-run
    clkSel = 3'd3; step(30);
    rst = 1'b1; step(1); rst = 1'b0; clkSel = 3'd0;
    check("R12 reset count", 32'(count), 0);
    check("R12 reset flags", 32'(flags), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule